// File: doc/BRIEF.md
# EPROM Byte Programming Sequencer

This block holds the control register and timing for writing a single byte of one-time-programmable memory, such as a configuration byte. Software first sets a latch-enable bit. The next ordinary data write on the register bus is then captured, both its address and its data. A program-enable bit is then set with a separate write. This drives the programming-voltage switch for a fixed number of clock cycles. When the pulse is over, software clears both bits.

The sequencer guards the high-voltage path in several ways. It refuses to arm unless a byte has been captured and the high-voltage supply reports present. It never switches the voltage on for an address outside the programmable window. When the latch bit is dropped, it discards everything at once. The memory cells and the high-voltage generator sit outside this block.

Top module: `eprom_prog_seq`

## Requirements
- R1: After reset, `ctrl_rdata`, `lat_addr`, `lat_data` and `vpp_en` are all zero.
- R2: The control register is written at address `CTRL_ADDR`. Bit 0 is the latch enable and bit 1 is the program enable. A single write of both bits while the latch bit is 0 sets the latch bit and leaves the program bit at 0.
- R3: While the latch bit is 1, only the first bus write to an address other than `CTRL_ADDR` is captured. That write drives `lat_addr`/`lat_data` and sets the captured flag (`ctrl_rdata` bit 2). Later data writes leave the captured values unchanged.
- R4: Data writes made while the latch bit is 0 capture nothing. `lat_addr`, `lat_data` and bit 2 stay 0.
- R5: A write setting bit 1 sets the program bit (`ctrl_rdata` bit 1) only if all three conditions hold. The latch bit was already 1 before that write, a byte has been captured, and `hv_ok` is 1. Otherwise the write is ignored.
- R6: Once the program bit sets, `vpp_en` is high for exactly `PULSE_CYCLES` clock cycles, starting the cycle after that write. It requires a valid address. The busy flag (bit 3) is high during that window. After the window, the done flag (bit 4) is high while the program bit stays set.
- R7: The captured address is valid when it lies in `VALID_LO`..`VALID_HI` inclusive. This is reported in bit 5. For any other address, `vpp_en` never rises.
- R8: A control write with bit 0 = 0 clears bits 0 to 5, `lat_addr`, `lat_data` and `vpp_en` by the next cycle. This also ends any pulse in progress.
- R9: A control write with bit 0 = 1 and bit 1 = 0 clears the program bit and ends the pulse by the next cycle. The latch bit and the captured byte are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | ADDR_W | Register bus address |
| bus_wdata | input | DATA_W | Register bus write data |
| bus_we | input | 1 | Register bus write strobe |
| hv_ok | input | 1 | Programming supply present |
| lat_addr | output | ADDR_W | Captured target address |
| lat_data | output | DATA_W | Captured target data |
| vpp_en | output | 1 | Programming-voltage switch enable |
| ctrl_rdata | output | DATA_W | Control/status: b0 latch, b1 program, b2 captured, b3 busy, b4 done, b5 address valid |

## Verification
The bench sweeps every bus address through a full capture-and-program sequence. It counts the cycles for which `vpp_en` is high and compares the count with the window rule. A design with an off-by-one counter, or with a missing or wrong range decode, shows up as a wrong count on some address. The combined both-bits write is checked separately. A design that armed on that write would start a pulse before any byte was latched. The bench also drops the latch bit and the program bit in the middle of a pulse. A design that only stopped at the end of the count would keep the high voltage on, or would keep stale address and data.

// File: rtl/eprom_prog_pkg.sv
package eprom_prog_pkg;
   localparam int CB_LAT  = 0;
   localparam int CB_PGM  = 1;
   localparam int CB_CAP  = 2;
   localparam int CB_BUSY = 3;
   localparam int CB_DONE = 4;
   localparam int CB_AOK  = 5;
   localparam int CB_NUM  = 6;

   function automatic logic in_window(input logic [31:0] a,
                                      input logic [31:0] lo,
                                      input logic [31:0] hi);
      return (a >= lo) && (a <= hi);
   endfunction
endpackage

// File: rtl/prog_ctrl_reg.sv
module prog_ctrl_reg #(
   parameter int ADDR_W = 8,
   parameter int DATA_W = 8,
   parameter logic [ADDR_W-1:0] CTRL_ADDR = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   input  logic              bus_we,
   input  logic              hv_ok,
   input  logic              captured,
   output logic              lat,
   output logic              pgm,
   output logic              pgm_start,
   output logic              lat_clr
);
   import eprom_prog_pkg::*;

   logic ctrl_wr;
   logic want_lat;
   logic want_pgm;

   assign ctrl_wr  = bus_we && (bus_addr == CTRL_ADDR);
   assign want_lat = bus_wdata[CB_LAT];
   assign want_pgm = bus_wdata[CB_PGM];

   // arming looks at the latch bit as it stood before this write
   assign pgm_start = ctrl_wr && want_lat && want_pgm && lat && !pgm
                      && captured && hv_ok;
   assign lat_clr   = ctrl_wr && !want_lat;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lat <= 1'b0;
         pgm <= 1'b0;
      end else if (ctrl_wr) begin
         if (!want_lat) begin
            lat <= 1'b0;
            pgm <= 1'b0;
         end else if (!lat) begin
            lat <= 1'b1;
            pgm <= 1'b0;
         end else if (!want_pgm) begin
            pgm <= 1'b0;
         end else if (pgm_start) begin
            pgm <= 1'b1;
         end
      end
   end
endmodule

// File: rtl/prog_capture.sv
module prog_capture #(
   parameter int ADDR_W = 8,
   parameter int DATA_W = 8,
   parameter logic [ADDR_W-1:0] CTRL_ADDR = '0,
   parameter bit RANGE_CHECK = 1'b1,
   parameter logic [ADDR_W-1:0] VALID_LO = '0,
   parameter logic [ADDR_W-1:0] VALID_HI = '1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   input  logic              bus_we,
   input  logic              lat,
   input  logic              lat_clr,
   output logic              captured,
   output logic [ADDR_W-1:0] cap_addr,
   output logic [DATA_W-1:0] cap_data,
   output logic              addr_ok
);
   import eprom_prog_pkg::*;

   logic data_wr;
   logic win_hit;

   assign data_wr = bus_we && (bus_addr != CTRL_ADDR);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         captured <= 1'b0;
         cap_addr <= '0;
         cap_data <= '0;
      end else if (!lat || lat_clr) begin
         captured <= 1'b0;
         cap_addr <= '0;
         cap_data <= '0;
      end else if (data_wr && !captured) begin
         captured <= 1'b1;
         cap_addr <= bus_addr;
         cap_data <= bus_wdata;
      end
   end

   generate
      if (RANGE_CHECK) begin : g_window
         assign win_hit = in_window(32'(cap_addr), 32'(VALID_LO), 32'(VALID_HI));
      end else begin : g_any
         assign win_hit = 1'b1;
      end
   endgenerate

   assign addr_ok = captured && win_hit;
endmodule

// File: rtl/prog_pulse_timer.sv
module prog_pulse_timer #(
   parameter int PULSE_CYCLES = 12
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   input  logic pgm,
   output logic active,
   output logic done
);
   localparam int CNT_W = $clog2(PULSE_CYCLES + 1);
   localparam logic [CNT_W-1:0] LOAD = CNT_W'(PULSE_CYCLES);

   logic [CNT_W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            cnt <= '0;
      else if (start)        cnt <= LOAD;
      else if (!pgm)         cnt <= '0;
      else if (cnt != '0)    cnt <= cnt - 1'b1;
   end

   assign active = pgm && (cnt != '0);
   assign done   = pgm && (cnt == '0);
endmodule

// File: rtl/eprom_prog_seq.sv
module eprom_prog_seq #(
   parameter int ADDR_W = 8,
   parameter int DATA_W = 8,
   parameter int PULSE_CYCLES = 12,
   parameter logic [ADDR_W-1:0] CTRL_ADDR = 8'h08,
   parameter bit RANGE_CHECK = 1'b1,
   parameter logic [ADDR_W-1:0] VALID_LO = 8'h40,
   parameter logic [ADDR_W-1:0] VALID_HI = 8'h7F
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   input  logic              bus_we,
   input  logic              hv_ok,
   output logic [ADDR_W-1:0] lat_addr,
   output logic [DATA_W-1:0] lat_data,
   output logic              vpp_en,
   output logic [DATA_W-1:0] ctrl_rdata
);
   import eprom_prog_pkg::*;

   initial begin
      assert (DATA_W >= CB_NUM) else $fatal(1, "DATA_W too narrow for status bits");
      assert (PULSE_CYCLES >= 1) else $fatal(1, "PULSE_CYCLES must be positive");
      assert (ADDR_W >= 1) else $fatal(1, "ADDR_W must be positive");
      assert (VALID_LO <= VALID_HI) else $fatal(1, "empty valid window");
   end

   logic lat, pgm, pgm_start, lat_clr;
   logic captured, addr_ok;
   logic t_active, t_done;

   prog_ctrl_reg #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CTRL_ADDR(CTRL_ADDR)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_we(bus_we), .hv_ok(hv_ok), .captured(captured),
      .lat(lat), .pgm(pgm), .pgm_start(pgm_start), .lat_clr(lat_clr)
   );

   prog_capture #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CTRL_ADDR(CTRL_ADDR),
                  .RANGE_CHECK(RANGE_CHECK), .VALID_LO(VALID_LO),
                  .VALID_HI(VALID_HI)) u_cap (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_we(bus_we), .lat(lat), .lat_clr(lat_clr), .captured(captured),
      .cap_addr(lat_addr), .cap_data(lat_data), .addr_ok(addr_ok)
   );

   prog_pulse_timer #(.PULSE_CYCLES(PULSE_CYCLES)) u_tmr (
      .clk(clk), .rst_n(rst_n), .start(pgm_start), .pgm(pgm),
      .active(t_active), .done(t_done)
   );

   assign vpp_en = t_active && addr_ok;

   always_comb begin
      ctrl_rdata          = '0;
      ctrl_rdata[CB_LAT]  = lat;
      ctrl_rdata[CB_PGM]  = pgm;
      ctrl_rdata[CB_CAP]  = captured;
      ctrl_rdata[CB_BUSY] = t_active;
      ctrl_rdata[CB_DONE] = t_done;
      ctrl_rdata[CB_AOK]  = addr_ok;
   end
endmodule

// File: rtl/eprom_prog_seq_chk.sv
module eprom_prog_seq_chk #(
   parameter int ADDR_W = 8,
   parameter int DATA_W = 8,
   parameter logic [ADDR_W-1:0] CTRL_ADDR = 8'h08,
   parameter bit RANGE_CHECK = 1'b1,
   parameter logic [ADDR_W-1:0] VALID_LO = 8'h40,
   parameter logic [ADDR_W-1:0] VALID_HI = 8'h7F
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [DATA_W-1:0] bus_wdata,
   input logic              bus_we,
   input logic              hv_ok,
   input logic [ADDR_W-1:0] lat_addr,
   input logic [DATA_W-1:0] lat_data,
   input logic              vpp_en,
   input logic [DATA_W-1:0] ctrl_rdata
);
   import eprom_prog_pkg::*;

   logic ctrl_wr;
   assign ctrl_wr = bus_we && (bus_addr == CTRL_ADDR);

   a_r2_both_bits_latch_only: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_wr && bus_wdata[CB_LAT] && bus_wdata[CB_PGM] && !ctrl_rdata[CB_LAT])
      |=> (ctrl_rdata[CB_LAT] && !ctrl_rdata[CB_PGM]));

   a_r3_capture_held: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_rdata[CB_CAP] && !ctrl_wr) |=> ($stable(lat_addr) && $stable(lat_data)));

   a_r5_arm_guarded: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ctrl_rdata[CB_PGM]) |->
         $past(ctrl_rdata[CB_LAT] && ctrl_rdata[CB_CAP] && hv_ok));

   a_r6_vpp_needs_pgm: assert property (@(posedge clk) disable iff (!rst_n)
      vpp_en |-> (ctrl_rdata[CB_PGM] && ctrl_rdata[CB_LAT]));

   a_r7_window_only: assert property (@(posedge clk) disable iff (!rst_n)
      vpp_en |-> (!RANGE_CHECK ||
                  in_window(32'(lat_addr), 32'(VALID_LO), 32'(VALID_HI))));

   a_r8_clear_all: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_wr && !bus_wdata[CB_LAT]) |=>
         (!vpp_en && ctrl_rdata[CB_NUM-1:0] == '0 && lat_addr == '0 && lat_data == '0));

   a_r9_pgm_drop: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_wr && bus_wdata[CB_LAT] && !bus_wdata[CB_PGM] && ctrl_rdata[CB_LAT])
      |=> (!vpp_en && !ctrl_rdata[CB_PGM] && ctrl_rdata[CB_LAT]));
endmodule

bind eprom_prog_seq eprom_prog_seq_chk #(
   .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CTRL_ADDR(CTRL_ADDR),
   .RANGE_CHECK(RANGE_CHECK), .VALID_LO(VALID_LO), .VALID_HI(VALID_HI)
) u_chk (
   .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
   .bus_we(bus_we), .hv_ok(hv_ok), .lat_addr(lat_addr), .lat_data(lat_data),
   .vpp_en(vpp_en), .ctrl_rdata(ctrl_rdata)
);

// File: tb/test_eprom_prog_seq.sv
module test_eprom_prog_seq;
   localparam int AW = 8;
   localparam int DW = 8;
   localparam int PC = 12;
   localparam logic [7:0] CA = 8'h08;
   localparam int LO = 8'h40;
   localparam int HI = 8'h7F;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [AW-1:0] bus_addr = '0;
   logic [DW-1:0] bus_wdata = '0;
   logic bus_we = 1'b0;
   logic hv_ok = 1'b1;
   logic [AW-1:0] lat_addr;
   logic [DW-1:0] lat_data;
   logic vpp_en;
   logic [DW-1:0] ctrl_rdata;

   int checks = 0;
   int errors = 0;

   always #5 clk = ~clk;

   eprom_prog_seq #(.ADDR_W(AW), .DATA_W(DW), .PULSE_CYCLES(PC), .CTRL_ADDR(CA),
                    .RANGE_CHECK(1'b1), .VALID_LO(8'(LO)), .VALID_HI(8'(HI))) i_eprom_prog_seq (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_we(bus_we), .hv_ok(hv_ok), .lat_addr(lat_addr), .lat_data(lat_data),
      .vpp_en(vpp_en), .ctrl_rdata(ctrl_rdata)
   );

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   // called at a falling edge; returns at the falling edge after the write
   task automatic wr(input logic [7:0] a, input logic [7:0] d);
      bus_addr = a; bus_wdata = d; bus_we = 1'b1;
      @(negedge clk);
      bus_we = 1'b0;
   endtask

   task automatic count_pulse(output int n);
      n = 0;
      for (int i = 0; i < PC + 3; i++) begin
         if (vpp_en) n++;
         @(negedge clk);
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      int n;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check("R1 ctrl", int'(ctrl_rdata), 0);
      check("R1 addr", int'(lat_addr), 0);
      check("R1 data", int'(lat_data), 0);
      check("R1 vpp", int'(vpp_en), 0);

      // R4 data write with latch off
      wr(8'h50, 8'h99);
      check("R4 captured", int'(ctrl_rdata[2]), 0);
      check("R4 data", int'(lat_data), 0);

      // R2 both bits at once
      wr(CA, 8'h03);
      check("R2 ctrl bits", int'(ctrl_rdata[1:0]), 1);
      @(negedge clk);
      check("R2 no pulse", int'(vpp_en), 0);

      // R5 arm with nothing captured
      wr(CA, 8'h03);
      check("R5 no capture", int'(ctrl_rdata[1]), 0);

      // R3 first capture then ignore
      wr(8'h45, 8'hA5);
      check("R3 addr", int'(lat_addr), 8'h45);
      check("R3 data", int'(lat_data), 8'hA5);
      check("R3 flag", int'(ctrl_rdata[2]), 1);
      wr(8'h46, 8'h5A);
      check("R3 second addr", int'(lat_addr), 8'h45);
      check("R3 second data", int'(lat_data), 8'hA5);

      // R5 supply absent
      hv_ok = 1'b0;
      wr(CA, 8'h03);
      check("R5 no hv", int'(ctrl_rdata[1]), 0);
      check("R5 no hv vpp", int'(vpp_en), 0);
      hv_ok = 1'b1;

      // R6 full pulse
      wr(CA, 8'h03);
      check("R6 pgm set", int'(ctrl_rdata[1]), 1);
      check("R6 busy", int'(ctrl_rdata[3]), 1);
      count_pulse(n);
      check("R6 width", n, PC);
      check("R6 done", int'(ctrl_rdata[4]), 1);
      check("R6 busy off", int'(ctrl_rdata[3]), 0);

      // R9 drop program bit, keep latch
      wr(CA, 8'h01);
      check("R9 ctrl", int'(ctrl_rdata[2:0]), 5);
      check("R9 addr kept", int'(lat_addr), 8'h45);

      // R9 mid-pulse
      wr(CA, 8'h03);
      repeat (3) @(negedge clk);
      check("R9 mid vpp on", int'(vpp_en), 1);
      wr(CA, 8'h01);
      check("R9 mid vpp off", int'(vpp_en), 0);
      check("R9 mid latch", int'(ctrl_rdata[0]), 1);

      // R8 mid-pulse clear
      wr(CA, 8'h03);
      repeat (2) @(negedge clk);
      wr(CA, 8'h00);
      check("R8 vpp", int'(vpp_en), 0);
      check("R8 ctrl", int'(ctrl_rdata[5:0]), 0);
      check("R8 addr", int'(lat_addr), 0);
      check("R8 data", int'(lat_data), 0);

      // R7/R6 sweep over every address
      for (int a = 0; a < 256; a++) begin
         int inwin;
         if (a == int'(CA)) continue;
         inwin = (a >= LO && a <= HI) ? 1 : 0;
         wr(CA, 8'h01);
         wr(8'(a), 8'(a ^ 8'h3C));
         check("R3 sweep addr", int'(lat_addr), a);
         check("R3 sweep data", int'(lat_data), (a ^ 8'h3C) & 8'hFF);
         check("R7 valid flag", int'(ctrl_rdata[5]), inwin);
         wr(CA, 8'h03);
         count_pulse(n);
         check("R7 sweep width", n, inwin ? PC : 0);
         check("R6 sweep done", int'(ctrl_rdata[4]), 1);
         wr(CA, 8'h00);
      end

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule